// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a bank of general-purpose pins with a small register file on a simple bus. The bus has an address, a write strobe, write data and read data. Software sets each pin's direction, drives output values and reads back both the sampled pin levels and the value it last latched for output. Each pin has an input, an output value and an output enable, so a pad-level tri-state buffer can be placed outside the block. The number of pins equals the register width, which is 8, 16, 32 or 64 bits.

Three compile-time choices fix the programming model. The first chooses the output update style. In paired mode one word raises the pins written as 1 and another word lowers the pins written as 1. In write-through mode a single store replaces the whole output latch. The second choice sets the direction polarity: either a 1 in the direction word means "drive" or it means "listen". The third choice can reverse the bit order, so that pin 0 sits in the most significant bit of every word. Pin levels pass through a two-flop synchroniser before software can see them.

Top module: `mmio_gpio_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the output latch is 0 and no pin is driven (gpio_oe all 0). The direction word then reads back as all zeros when a 1 in it means output (DIR_IS_OUT=1), and as all ones when a 1 in it means input (DIR_IS_OUT=0).
- R2: A read at byte offset 0x0 returns the pin inputs as they were two clock edges earlier, with 1 meaning the line is high. A pin change therefore does not show after one edge and does show after two.
- R3: With SETCLR_MODE=1, a write to offset 0x4 sets the latch bits written as 1 and leaves the bits written as 0 unchanged.
- R4: With SETCLR_MODE=1, a write to offset 0x8 clears the latch bits written as 1 and leaves the bits written as 0 unchanged.
- R5: With SETCLR_MODE=1, a write to offset 0x0 does not change the output latch.
- R6: With SETCLR_MODE=0, a write to offset 0x0 or to offset 0x4 replaces the whole latch with the written word, and a write to offset 0x8 is ignored.
- R7: A read at offset 0x4 returns the output latch and a read at 0x0xC returns the direction word as written. A read at 0x8 or at any unmapped offset returns 0, and a write to an unmapped offset changes nothing.
- R8: With DIR_IS_OUT=1 a pin's output enable equals its direction bit. With DIR_IS_OUT=0 it equals the inverse of that bit. The enables change only on a write to offset 0xC.
- R9: Each pin's output value equals its latch bit whatever its direction.
- R10: With MIRROR=1, pin n corresponds to bit DATA_W-1-n of every word read or written. With MIRROR=0, pin n corresponds to bit n.
- R11: A write takes effect at the clock edge on which the strobe is sampled. The outputs are unchanged before that edge and hold their value in cycles with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr_en | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| gpio_i | input | DATA_W | Pin levels, one bit per pin, pin n on bit n |
| gpio_o | output | DATA_W | Output value per pin |
| gpio_oe | output | DATA_W | Output enable per pin, 1 drives the pin |

## Verification
The assertions assume that bus_addr, bus_wr_en and bus_wdata are steady around each rising edge. They also assume that bus_rdata is only meaningful for the address presented in the same cycle, and that gpio_i may change at any cycle boundary. The bench changes every input at the falling edge, so each value is settled a half period before the edge that samples it. The random stimulus mixes mapped and unmapped offsets, full random data words, and pin changes held at least two cycles before the data word is checked.

// File: rtl/gpio_ctrl_pkg.sv
`timescale 1ns/1ps
// Package gpio_ctrl_pkg
// Shared register offsets and the decoded register select for the GPIO
// controller. It assumes byte offsets of at most 16 bits.
package gpio_ctrl_pkg;

    localparam logic [15:0] OFF_LEVEL = 16'h0000;
    localparam logic [15:0] OFF_RAISE = 16'h0004;
    localparam logic [15:0] OFF_LOWER = 16'h0008;
    localparam logic [15:0] OFF_DIR   = 16'h000C;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_LEVEL = 3'd1,
        SEL_RAISE = 3'd2,
        SEL_LOWER = 3'd3,
        SEL_DIR   = 3'd4
    } gpio_sel_e;

    // Map a byte offset to a register select; an unmapped offset gives SEL_NONE.
    function automatic gpio_sel_e decode_offset(input logic [15:0] off);
        gpio_sel_e sel;
        case (off)
            OFF_LEVEL: sel = SEL_LEVEL;
            OFF_RAISE: sel = SEL_RAISE;
            OFF_LOWER: sel = SEL_LOWER;
            OFF_DIR:   sel = SEL_DIR;
            default:   sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/gpio_bit_order.sv
`timescale 1ns/1ps
// Module gpio_bit_order
// Maps a bus word to pin order. When MIRROR is set, bit i maps to bit
// W-1-i. The mapping is its own inverse, so the same module serves the
// write path and the read path. Purely combinational.
module gpio_bit_order #(
    parameter int W      = 32,
    parameter bit MIRROR = 1'b0
) (
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);

    generate
        if (MIRROR) begin : g_mirror
            for (genvar i = 0; i < W; i++) begin : g_bit
                // Reverse the position of each bit.
                assign dst[i] = src[W-1-i];
            end
        end else begin : g_straight
            // Keep the natural order.
            assign dst = src;
        end
    endgenerate

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Module gpio_in_sync
// Multi-stage synchroniser for the asynchronous pin levels. It assumes
// STAGES >= 2. Every stage clears on reset, so after reset the data word
// reads 0 until STAGES edges have passed.
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic [W-1:0] pins_sync
);

    logic [STAGES-1:0][W-1:0] chain;

    // Shift the pin sample one stage deeper on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], pins};
        end
    end

    assign pins_sync = chain[STAGES-1];

endmodule

// File: rtl/gpio_out_regs.sv
`timescale 1ns/1ps
// Module gpio_out_regs
// Holds the output latch and the direction word, both in pin order.
// SETCLR_MODE chooses paired raise/lower updates or whole-word
// write-through. DIR_IS_OUT chooses the polarity of the direction word.
// It assumes the select is already decoded from the bus offset.
module gpio_out_regs
    import gpio_ctrl_pkg::*;
#(
    parameter int W           = 32,
    parameter bit SETCLR_MODE = 1'b1,
    parameter bit DIR_IS_OUT  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  gpio_sel_e    sel,
    input  logic [W-1:0] wline,
    output logic [W-1:0] latch,
    output logic [W-1:0] dir_word,
    output logic [W-1:0] oe
);

    // Direction word that leaves every pin undriven.
    localparam logic [W-1:0] DIR_RESET = {W{~DIR_IS_OUT}};

    logic [W-1:0] latch_nxt;
    logic [W-1:0] dir_nxt;

    generate
        if (SETCLR_MODE) begin : g_pair
            // Paired mode: one word raises the marked pins, the other lowers them.
            always_comb begin
                latch_nxt = latch;
                if (wr_en) begin
                    case (sel)
                        SEL_RAISE: latch_nxt = latch | wline;
                        SEL_LOWER: latch_nxt = latch & ~wline;
                        default:   latch_nxt = latch;
                    endcase
                end
            end
        end else begin : g_through
            // Write-through mode: the level or raise offset replaces the whole latch.
            always_comb begin
                latch_nxt = latch;
                if (wr_en) begin
                    case (sel)
                        SEL_LEVEL,
                        SEL_RAISE: latch_nxt = wline;
                        default:   latch_nxt = latch;
                    endcase
                end
            end
        end
    endgenerate

    // Next direction word: replaced only by a write to the direction offset.
    always_comb begin
        dir_nxt = dir_word;
        if (wr_en && (sel == SEL_DIR)) begin
            dir_nxt = wline;
        end
    end

    // State update with synchronous reset to the safe, undriven state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch    <= '0;
            dir_word <= DIR_RESET;
        end else begin
            latch    <= latch_nxt;
            dir_word <= dir_nxt;
        end
    end

    generate
        if (DIR_IS_OUT) begin : g_dir_out
            // A 1 in the direction word enables the driver.
            assign oe = dir_word;
        end else begin : g_dir_in
            // A 1 in the direction word marks an input, so invert it.
            assign oe = ~dir_word;
        end
    endgenerate

endmodule

// File: rtl/gpio_read_mux.sv
`timescale 1ns/1ps
// Module gpio_read_mux
// Selects the pin-order value returned for a read. The lower offset and
// unmapped offsets return zero. Purely combinational.
module gpio_read_mux
    import gpio_ctrl_pkg::*;
#(
    parameter int W = 32
) (
    input  gpio_sel_e    sel,
    input  logic [W-1:0] pins_sync,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] dir_word,
    output logic [W-1:0] rline
);

    // Choose the source of the read word by register select.
    always_comb begin
        case (sel)
            SEL_LEVEL: rline = pins_sync;
            SEL_RAISE: rline = latch;
            SEL_DIR:   rline = dir_word;
            default:   rline = '0;
        endcase
    end

endmodule

// File: rtl/mmio_gpio_ctrl.sv
`timescale 1ns/1ps
// Module mmio_gpio_ctrl
// Top of the GPIO controller: decodes the offset, maps the bit order,
// synchronises the pins, and holds the output latch and direction word.
// It assumes DATA_W is 8, 16, 32 or 64 and ADDR_W is between 4 and 16.
// Reads are combinational from the address; writes act at the rising edge.
module mmio_gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter bit SETCLR_MODE = 1'b1,
    parameter bit DIR_IS_OUT  = 1'b1,
    parameter bit MIRROR      = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] gpio_i,
    output logic [DATA_W-1:0] gpio_o,
    output logic [DATA_W-1:0] gpio_oe
);

    gpio_sel_e         sel;
    logic [DATA_W-1:0] wline;
    logic [DATA_W-1:0] rline;
    logic [DATA_W-1:0] pins_sync;
    logic [DATA_W-1:0] latch;
    logic [DATA_W-1:0] dir_word;

    // Decode the byte offset once for both paths.
    assign sel = decode_offset(16'(bus_addr));

    gpio_bit_order #(.W(DATA_W), .MIRROR(MIRROR)) u_wmap (
        .src (bus_wdata),
        .dst (wline)
    );

    gpio_in_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (gpio_i),
        .pins_sync (pins_sync)
    );

    gpio_out_regs #(
        .W           (DATA_W),
        .SETCLR_MODE (SETCLR_MODE),
        .DIR_IS_OUT  (DIR_IS_OUT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .sel      (sel),
        .wline    (wline),
        .latch    (latch),
        .dir_word (dir_word),
        .oe       (gpio_oe)
    );

    gpio_read_mux #(.W(DATA_W)) u_rmux (
        .sel       (sel),
        .pins_sync (pins_sync),
        .latch     (latch),
        .dir_word  (dir_word),
        .rline     (rline)
    );

    gpio_bit_order #(.W(DATA_W), .MIRROR(MIRROR)) u_rmap (
        .src (rline),
        .dst (bus_rdata)
    );

    // Each pin drives the value held in its latch bit.
    assign gpio_o = latch;

endmodule

// File: rtl/gpio_ctrl_checker.sv
`timescale 1ns/1ps
// Module gpio_ctrl_checker
// Property checker bound to mmio_gpio_ctrl. It observes only the ports of
// the top module. It assumes the bus inputs are steady at each rising edge.
module gpio_ctrl_checker
    import gpio_ctrl_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter bit SETCLR_MODE = 1'b1,
    parameter bit MIRROR      = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] gpio_i,
    input logic [DATA_W-1:0] gpio_o,
    input logic [DATA_W-1:0] gpio_oe
);

    // Pin-order view of a bus word.
    function automatic logic [DATA_W-1:0] to_pins(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) begin
            r[i] = MIRROR ? v[DATA_W-1-i] : v[i];
        end
        return r;
    endfunction

    logic [DATA_W-1:0] wpins;
    logic [15:0]       off;
    logic [1:0]        since_rst;

    assign wpins = to_pins(bus_wdata);
    assign off   = 16'(bus_addr);

    // Count edges since reset release, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_RESET_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gpio_oe == '0) && (gpio_o == '0)); // R1

    AST_LEVEL_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) && (off == OFF_LEVEL) |-> bus_rdata == to_pins($past(gpio_i, 2))); // R2

    AST_LOWER_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (off == OFF_LOWER) |-> bus_rdata == '0); // R7

    AST_OE_ONLY_ON_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && (off == OFF_DIR)) |=> $stable(gpio_oe)); // R8

    AST_IDLE_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_en |=> $stable(gpio_o)); // R11

    generate
        if (SETCLR_MODE) begin : g_pair_props
            AST_RAISE_MARKED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                bus_wr_en && (off == OFF_RAISE) |=>
                    ((gpio_o & $past(wpins)) == $past(wpins)) &&
                    ((gpio_o & ~$past(wpins)) == ($past(gpio_o) & ~$past(wpins)))); // R3

            AST_LOWER_MARKED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                bus_wr_en && (off == OFF_LOWER) |=>
                    ((gpio_o & $past(wpins)) == '0) &&
                    ((gpio_o & ~$past(wpins)) == ($past(gpio_o) & ~$past(wpins)))); // R4

            AST_LEVEL_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
                bus_wr_en && (off == OFF_LEVEL) |=> $stable(gpio_o)); // R5
        end else begin : g_through_props
            AST_THROUGH_REPLACES: assert property (@(posedge clk) disable iff (!rst_n)
                bus_wr_en && ((off == OFF_LEVEL) || (off == OFF_RAISE)) |=>
                    gpio_o == $past(wpins)); // R6

            AST_THROUGH_LOWER_INERT: assert property (@(posedge clk) disable iff (!rst_n)
                bus_wr_en && (off == OFF_LOWER) |=> $stable(gpio_o)); // R6
        end
    endgenerate

endmodule

bind mmio_gpio_ctrl gpio_ctrl_checker #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .SETCLR_MODE (SETCLR_MODE),
    .MIRROR      (MIRROR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpio_i    (gpio_i),
    .gpio_o    (gpio_o),
    .gpio_oe   (gpio_oe)
);

// File: tb/mmio_gpio_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for mmio_gpio_ctrl. Unit 0 (dut_i) uses the defaults: 32 bits,
// paired raise/lower, a 1 means output, natural order. Unit 1 (dut_alt_i)
// is 16 bits, write-through, a 1 means input, mirrored.
module mmio_gpio_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [3:0]  addr_a = '0, addr_b = '0;
    logic        we_a = 1'b0, we_b = 1'b0;
    logic [31:0] wd_a = '0, rd_a, pin_a = '0, o_a, oe_a;
    logic [15:0] wd_b = '0, rd_b, pin_b = '0, o_b, oe_b;

    mmio_gpio_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr_a), .bus_wr_en(we_a),
        .bus_wdata(wd_a), .bus_rdata(rd_a), .gpio_i(pin_a), .gpio_o(o_a), .gpio_oe(oe_a)
    );

    mmio_gpio_ctrl #(
        .DATA_W(16), .ADDR_W(4), .SETCLR_MODE(1'b0), .DIR_IS_OUT(1'b0), .MIRROR(1'b1)
    ) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr_b), .bus_wr_en(we_b),
        .bus_wdata(wd_b), .bus_rdata(rd_b), .gpio_i(pin_b), .gpio_o(o_b), .gpio_oe(oe_b)
    );

    int nvec = 0;
    int nfail = 0;
    logic [63:0] m_lat [2];
    logic [63:0] m_dir [2];
    logic [63:0] m_pin [2];

    function automatic logic [63:0] wmask(input int u);
        return (u == 0) ? 64'hFFFF_FFFF : 64'hFFFF;
    endfunction

    // Pin-order value of a bus word: unit 1 is mirrored over 16 bits.
    function automatic logic [63:0] order(input int u, input logic [63:0] v);
        logic [63:0] r = '0;
        if (u == 0) return v & wmask(0);
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    function automatic logic [63:0] exp_oe(input int u);
        return (u == 0) ? m_dir[0] : (~m_dir[1] & wmask(1));
    endfunction

    function automatic logic [63:0] exp_read(input int u, input logic [3:0] a);
        logic [63:0] v;
        case (a)
            4'h0:    v = m_pin[u];
            4'h4:    v = m_lat[u];
            4'hC:    v = m_dir[u];
            default: v = '0;
        endcase
        return order(u, v);
    endfunction

    function automatic logic [63:0] cur_o(input int u);
        return (u == 0) ? {32'b0, o_a} : {48'b0, o_b};
    endfunction
    function automatic logic [63:0] cur_oe(input int u);
        return (u == 0) ? {32'b0, oe_a} : {48'b0, oe_b};
    endfunction
    function automatic logic [63:0] cur_rd(input int u);
        return (u == 0) ? {32'b0, rd_a} : {48'b0, rd_b};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input int u, input logic [3:0] a, input logic [63:0] d, input logic we);
        if (u == 0) begin addr_a = a; wd_a = d[31:0]; we_a = we; end
        else        begin addr_b = a; wd_b = d[15:0]; we_b = we; end
    endtask

    // Model of one register write per the requirements.
    task automatic model_write(input int u, input logic [3:0] a, input logic [63:0] d);
        logic [63:0] ln = order(u, d);
        if (u == 0) begin
            case (a)
                4'h4: m_lat[0] = m_lat[0] | ln;
                4'h8: m_lat[0] = m_lat[0] & ~ln;
                4'hC: m_dir[0] = ln;
                default: ;
            endcase
        end else begin
            case (a)
                4'h0, 4'h4: m_lat[1] = ln;
                4'hC:       m_dir[1] = ln;
                default: ;
            endcase
        end
    endtask

    task automatic do_write(input int u, input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        drive(u, a, d, 1'b1);
        #1 check("R11 outputs held before edge", cur_o(u), m_lat[u]);
        model_write(u, a, d);
        @(negedge clk);
        drive(u, a, d, 1'b0);
        #1;
        check("R9 gpio_o equals latch", cur_o(u), m_lat[u]);
        check("R8 gpio_oe from direction", cur_oe(u), exp_oe(u));
    endtask

    task automatic do_read(input int u, input logic [3:0] a, input string req);
        @(negedge clk);
        drive(u, a, '0, 1'b0);
        #1 check(req, cur_rd(u), exp_read(u, a));
    endtask

    // Change pins, then confirm the level word lags by exactly two edges.
    task automatic set_pins(input int u, input logic [63:0] v);
        @(negedge clk);
        if (u == 0) pin_a = v[31:0]; else pin_b = v[15:0];
        do_read(u, 4'h0, "R2 level after one edge still old");
        m_pin[u] = v & wmask(u);
        do_read(u, 4'h0, "R2 level after two edges");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin : stim
        logic [3:0] addrs [8] = '{4'h0, 4'h4, 4'h8, 4'hC, 4'h1, 4'h2, 4'h6, 4'hE};
        void'($urandom(32'd1357));
        for (int u = 0; u < 2; u++) begin
            m_lat[u] = '0;
            m_pin[u] = '0;
        end
        m_dir[0] = '0;
        m_dir[1] = 64'hFFFF;
        repeat (4) @(negedge clk);
        #1;
        check("R1 gpio_oe zero in reset", cur_oe(0), 64'h0);
        rst_n = 1'b1;
        #1;
        check("R1 gpio_o zero after reset", cur_o(0), 64'h0);
        check("R1 gpio_oe zero after reset", cur_oe(0), 64'h0);
        check("R1 alt gpio_oe zero after reset", cur_oe(1), 64'h0);
        do_read(0, 4'hC, "R1 direction reads zero");
        do_read(1, 4'hC, "R1 alt direction reads all ones");
        do_read(0, 4'h4, "R1 latch reads zero");

        // Paired mode on unit 0.
        do_write(0, 4'h4, 64'h0000_00F0);
        do_write(0, 4'h4, 64'h0000_000F);
        check("R3 raise keeps unmarked bits", cur_o(0), 64'hFF);
        do_write(0, 4'h8, 64'h0000_003C);
        check("R4 lower clears only marked bits", cur_o(0), 64'hC3);
        do_write(0, 4'h0, 64'hFFFF_FFFF);
        check("R5 level write ignored", cur_o(0), 64'hC3);
        do_write(0, 4'h2, 64'hFFFF_FFFF);
        do_read(0, 4'h4, "R7 unmapped write ignored");
        do_read(0, 4'h8, "R7 lower offset reads zero");
        do_read(0, 4'h1, "R7 unmapped read zero");
        do_write(0, 4'hC, 64'h0000_FFFF);
        check("R8 direction 1 drives", cur_oe(0), 64'hFFFF);
        do_read(0, 4'hC, "R7 direction readback");

        // Write-through, inverted direction, mirrored order on unit 1.
        do_write(1, 4'h4, 64'h0001);
        check("R10 pin 15 from bit 0", cur_o(1), 64'h8000);
        do_write(1, 4'h0, 64'h1234);
        check("R6 level write replaces", cur_o(1), 64'h2C48);
        do_write(1, 4'h8, 64'hFFFF);
        check("R6 lower write ignored", cur_o(1), 64'h2C48);
        do_write(1, 4'hC, 64'h0002);
        check("R8 R10 inverted mirrored direction", cur_oe(1), 64'hBFFF);
        set_pins(1, 64'h0001);
        check("R10 pin 0 read on bit 15", cur_rd(1), 64'h8000);
        set_pins(0, 64'hA5A5_0F0F);

        // Random mix per unit.
        for (int u = 0; u < 2; u++) begin
            for (int k = 0; k < 300; k++) begin
                int r = $urandom % 10;
                if (r < 2) begin
                    set_pins(u, {32'b0, $urandom} & wmask(u));
                end else begin
                    do_write(u, addrs[$urandom % 8], {32'b0, $urandom} & wmask(u));
                    do_read(u, addrs[$urandom % 8], "R7 random readback");
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule